// File: doc/BRIEF.md
# Indirection PRNG Core

This core generates a stream of 32-bit pseudo-random words. It holds a 256-word state table and a 256-word result table, both 32 bits wide, plus two 32-bit registers: an accumulator and the last result. Each step reads the table at three addresses derived from the loop index and from data fetched earlier. It updates the accumulator with a shift-XOR mix and writes a new state word back. It then reads the table again at an address taken from that new word, forms the result, and stores it in the result table. One pass of 256 steps produces 256 words. The accumulator, the last result and the state table all survive from one pass to the next, so the internal seed never leaves the core.

Loading works as a stream. While the core is idle, the host presents 258 words on the seed port: the state table in index order, then the accumulator, then the last-result register. A start strobe then launches one pass. Each step is split into two phases of four clock cycles each, so both tables can be single-port memories. Phase one gathers the operands and forms the new state word. Phase two writes that word back, performs the dependent read and commits the result. Every result is presented for one cycle with a valid flag.

Top module: `prng_core`

States: `ST_IDLE` (waiting; accepts seed words and start), `ST_RD_X`, `ST_RD_HALF`, `ST_RD_IND`, `ST_SUM_Y` (phase one), `ST_WR_Y`, `ST_RD_Y`, `ST_NEW_B`, `ST_EMIT` (phase two). Transitions: `ST_IDLE` to `ST_RD_X` on an accepted start. Each working state moves to the next one in the order listed. `ST_EMIT` returns to `ST_RD_X`, or to `ST_IDLE` after index 255.

## Requirements
- R1: Reset drives out_valid low and clears the accumulator, the last-result register, the step index, the seed word counter and the "seeded" condition. After reset, start has no effect until a complete seed stream has been loaded.
- R2: In idle, each cycle with seed_valid high consumes one word. Words 0 to 255 go to state entries 0 to 255. Word 256 goes to the accumulator and word 257 to the last-result register. A partial stream may be resumed later from where it stopped.
- R3: Start is ignored while fewer than all 258 seed words have been loaded, in a cycle where seed_valid is high, and while a pass is running.
- R4: For step i, x is state[i]. The accumulator becomes ((A << 19) XOR (A >> 13)) + state[(i+128) mod 256], in 32-bit arithmetic.
- R5: The new state word is y = state[x mod 256] + A + B modulo 2^32, using the updated A, and it is written back to state[i].
- R6: The new B is state[(y >> 8) mod 256] + x. It is written to result[i] and presented on out_data.
- R7: When (y >> 8) mod 256 equals i, the dependent read returns the y written earlier in the same step, not the old entry.
- R8: out_valid is a one-cycle pulse, with consecutive pulses exactly 8 cycles apart. Results appear in increasing i, 256 per pass, and out_data holds its value between pulses.
- R9: After a pass the core returns to idle. A later start continues from the carried-over state table, accumulator and last result.
- R10: seed_valid during a pass has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_valid | input | 1 | One seed word present this cycle |
| seed_data | input | 32 | Seed word |
| start | input | 1 | Launch one 256-step pass |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 32 | Result word |

## Verification
The hardest case to reach is R7, a step whose dependent index lands on the entry just rewritten, because the index comes from a sum of table data and two registers. The bench builds a seed where both registers are zero and state[128] is zero. state[0] is set to 5 and state[5] to a word whose bits 15:8 are zero, so step 0 reads back its own fresh write. The first result is then 0x1234007C, while a stale read would give 0x0000000A. The full 256-word sequences of two passes and a second seed are compared against a bench model. This gives far more than 1024 bits of output.

// File: rtl/prng_pkg.sv
package prng_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_X,
        ST_RD_HALF,
        ST_RD_IND,
        ST_SUM_Y,
        ST_WR_Y,
        ST_RD_Y,
        ST_NEW_B,
        ST_EMIT
    } prng_state_t;
endpackage

// File: rtl/prng_spram.sv
module prng_spram #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // write-first: a write also returns the new word on rdata
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
                rdata     <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/prng_mix.sv
module prng_mix #(
    parameter int DW  = 32,
    parameter int SHL = 19,
    parameter int SHR = 13
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] addend,
    output logic [DW-1:0] acc_next
);
    logic [DW-1:0] scrambled;

    assign scrambled = (acc << SHL) ^ (acc >> SHR);
    assign acc_next  = scrambled + addend;
endmodule

// File: rtl/prng_fsm.sv
module prng_fsm
    import prng_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        last_step,
    output prng_state_t state
);
    prng_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (go) state_nx = ST_RD_X;
            ST_RD_X:    state_nx = ST_RD_HALF;
            ST_RD_HALF: state_nx = ST_RD_IND;
            ST_RD_IND:  state_nx = ST_SUM_Y;
            ST_SUM_Y:   state_nx = ST_WR_Y;
            ST_WR_Y:    state_nx = ST_RD_Y;
            ST_RD_Y:    state_nx = ST_NEW_B;
            ST_NEW_B:   state_nx = ST_EMIT;
            ST_EMIT:    state_nx = last_step ? ST_IDLE : ST_RD_X;
            default:    state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/prng_core.sv
module prng_core
    import prng_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int SHL    = 19,
    parameter int SHR    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_valid,
    input  logic [DATA_W-1:0] seed_data,
    input  logic              start,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int CNT_W = $clog2(DEPTH + 2);
    localparam logic [CNT_W-1:0] CNT_A    = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_B    = CNT_W'(DEPTH + 1);
    localparam logic [IDX_W-1:0] HALF_OFS = {1'b1, {(IDX_W-1){1'b0}}};
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    prng_state_t       state;
    logic [DATA_W-1:0] a_q, b_q, x_q, y_q, a_mixed;
    logic [IDX_W-1:0]  step;
    logic [CNT_W-1:0]  seed_cnt;
    logic              seeded, go, last_step, valid_q;

    logic              m_en, m_we;
    logic [IDX_W-1:0]  m_addr;
    logic [DATA_W-1:0] m_wdata, m_rdata;
    logic              r_we;
    logic [DATA_W-1:0] r_rdata;

    assign go        = start && seeded && !seed_valid;
    assign last_step = (step == LAST_IDX);

    prng_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .last_step (last_step),
        .state     (state)
    );

    prng_mix #(.DW(DATA_W), .SHL(SHL), .SHR(SHR)) u_mix (
        .acc      (a_q),
        .addend   (m_rdata),
        .acc_next (a_mixed)
    );

    prng_spram #(.DW(DATA_W), .AW(IDX_W)) u_state_mem (
        .clk   (clk),
        .en    (m_en),
        .we    (m_we),
        .addr  (m_addr),
        .wdata (m_wdata),
        .rdata (m_rdata)
    );

    prng_spram #(.DW(DATA_W), .AW(IDX_W)) u_result_mem (
        .clk   (clk),
        .en    (r_we),
        .we    (r_we),
        .addr  (step),
        .wdata (b_q),
        .rdata (r_rdata)
    );

    // memory port schedule per state
    always_comb begin
        m_en    = 1'b0;
        m_we    = 1'b0;
        m_addr  = step;
        m_wdata = y_q;
        unique case (state)
            ST_IDLE: begin
                if (seed_valid && seed_cnt < CNT_A) begin
                    m_en    = 1'b1;
                    m_we    = 1'b1;
                    m_addr  = seed_cnt[IDX_W-1:0];
                    m_wdata = seed_data;
                end
            end
            ST_RD_X:    m_en = 1'b1;
            ST_RD_HALF: begin
                m_en   = 1'b1;
                m_addr = step + HALF_OFS;
            end
            ST_RD_IND: begin
                m_en   = 1'b1;
                m_addr = x_q[IDX_W-1:0];
            end
            ST_WR_Y: begin
                m_en = 1'b1;
                m_we = 1'b1;
            end
            ST_RD_Y: begin
                m_en   = 1'b1;
                m_addr = y_q[2*IDX_W-1:IDX_W];
            end
            default: ;
        endcase
    end

    assign r_we = (state == ST_EMIT);

    // datapath and seeding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            x_q      <= '0;
            y_q      <= '0;
            step     <= '0;
            seed_cnt <= '0;
            seeded   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (seed_valid) begin
                        if (seed_cnt == '0) seeded <= 1'b0;
                        if (seed_cnt == CNT_A) a_q <= seed_data;
                        if (seed_cnt == CNT_B) begin
                            b_q      <= seed_data;
                            seeded   <= 1'b1;
                            seed_cnt <= '0;
                        end else begin
                            seed_cnt <= seed_cnt + CNT_W'(1);
                        end
                    end
                end
                ST_RD_HALF: x_q  <= m_rdata;
                ST_RD_IND:  a_q  <= a_mixed;
                ST_SUM_Y:   y_q  <= m_rdata + a_q + b_q;
                ST_NEW_B:   b_q  <= m_rdata + x_q;
                ST_EMIT:    step <= step + IDX_W'(1);
                default: ;
            endcase
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= (state == ST_EMIT);
    end

    assign out_valid = valid_q;
    assign out_data  = r_rdata;
endmodule

// File: rtl/prng_core_chk.sv
module prng_core_chk
    import prng_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input prng_state_t       state,
    input logic              seeded,
    input logic [CNT_W-1:0]  seed_cnt,
    input logic [IDX_W-1:0]  step,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    // R8: a result is flagged for exactly one cycle
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: the result word holds between pulses
    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R3: without a complete seed the core stays idle
    a_r3_start_needs_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !seeded) |=> state == ST_IDLE);

    // R10: seed traffic leaves loading state alone during a pass
    a_r10_seed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(seed_cnt) && $stable(seeded)));

    // R9: the last step hands control back to idle
    a_r9_pass_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && step == {IDX_W{1'b1}}) |=> state == ST_IDLE);
endmodule

bind prng_core prng_core_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .seeded    (seeded),
    .seed_cnt  (seed_cnt),
    .step      (step),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/prng_core_tb_top.sv
module prng_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_valid = 1'b0;
    logic [31:0] seed_data = '0;
    logic        start = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] seed_buf [258];
    logic [31:0] mdl_m [256];
    logic [31:0] mdl_a, mdl_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    prng_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_valid (seed_valid),
        .seed_data  (seed_data),
        .start      (start),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic fill_seed(input logic [31:0] s, input logic [31:0] a0,
                             input logic [31:0] b0, input bit alias_case);
        logic [31:0] v = s;
        for (int k = 0; k < 256; k++) begin
            v = v * 32'd1664525 + 32'd1013904223;
            seed_buf[k] = v;
        end
        if (alias_case) begin
            seed_buf[0]   = 32'd5;
            seed_buf[5]   = 32'h1234_0077;
            seed_buf[128] = 32'd0;
        end
        seed_buf[256] = a0;
        seed_buf[257] = b0;
        for (int k = 0; k < 256; k++) mdl_m[k] = seed_buf[k];
        mdl_a = a0;
        mdl_b = b0;
    endtask

    task automatic send_words(input int first, input int count);
        for (int k = first; k < first + count; k++) begin
            @(negedge clk);
            seed_valid = 1'b1;
            seed_data  = seed_buf[k];
        end
        @(negedge clk);
        seed_valid = 1'b0;
    endtask

    task automatic mdl_step(input int i, output logic [31:0] r);
        logic [31:0] x, y;
        x = mdl_m[i];
        mdl_a = ({mdl_a[12:0], 19'd0} ^ {13'd0, mdl_a[31:13]}) + mdl_m[(i + 128) % 256];
        y = mdl_m[x[7:0]] + mdl_a + mdl_b;
        mdl_m[i] = y;
        mdl_b = mdl_m[y[15:8]] + x;
        r = mdl_b;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        int seen = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check(seen == 0, req, "no output expected", 32'(seen), 32'd0);
    endtask

    // one full pass compared against the model
    task automatic run_pass(input string tag, input bit disturb, input bit alias_first);
        int got = 0;
        int last_c = 0;
        int bad_gap = 0;
        logic [31:0] exp;
        @(negedge clk);
        start = 1'b1;
        for (int c = 0; c < 256 * 8 + 40; c++) begin
            @(negedge clk);
            start = 1'b0;
            seed_valid = 1'b0;
            if (disturb && (c == 30 || c == 700)) begin
                seed_valid = 1'b1;
                seed_data  = 32'hA5A5_5A5A;
                start      = 1'b1;
            end
            if (out_valid) begin
                mdl_step(got, exp);
                check(out_data == exp, "R6", {tag, " result vs model"}, out_data, exp);
                if (alias_first && got == 0)
                    check(out_data == 32'h1234_007C, "R7", "same-step readback", out_data, 32'h1234_007C);
                if (got > 0 && c - last_c != 8) bad_gap++;
                last_c = c;
                got++;
            end
        end
        start = 1'b0;
        seed_valid = 1'b0;
        check(got == 256, "R8", {tag, " result count"}, 32'(got), 32'd256);
        check(bad_gap == 0, "R8", {tag, " pulse spacing"}, 32'(bad_gap), 32'd0);
    endtask

    task automatic t_reset_state();
        check(out_valid == 1'b0, "R1", "valid in reset", 32'(out_valid), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid after reset", 32'(out_valid), 32'd0);
        pulse_start();
        expect_quiet(40, "R1");
    endtask

    task automatic t_partial_seed();
        fill_seed(32'h0000_1357, 32'd0, 32'd0, 1'b1);
        send_words(0, 100);
        pulse_start();
        expect_quiet(30, "R3");
        send_words(100, 158);
    endtask

    task automatic t_first_pass();
        run_pass("pass1", 1'b0, 1'b1);
        expect_quiet(30, "R9");
    endtask

    task automatic t_second_pass();
        run_pass("pass2 R9 R10", 1'b1, 1'b0);
    endtask

    task automatic t_reseed();
        fill_seed(32'hCAFE_0001, 32'h9E37_79B9, 32'h7F4A_7C15, 1'b0);
        send_words(0, 258);
        run_pass("reseed R2 R4 R5", 1'b0, 1'b0);
    endtask

    task automatic t_reset_mid_pass();
        pulse_start();
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid during mid-pass reset", 32'(out_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        pulse_start();
        expect_quiet(60, "R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_partial_seed();
        t_first_pass();
        t_second_pass();
        t_reseed();
        t_reset_mid_pass();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule